// File: doc/BRIEF.md
# Configuration Image Keeper

This block owns a small non-volatile configuration image held in a serial EEPROM. When reset is released it fetches the whole image, one word per request, into a local register file. While the words stream in it runs two checks. The first compares the word at the signature position with a fixed constant. The second compares the last word with the 16-bit wraparound sum of all the words before it. It does not drive EEPROM pins. It sends operation requests to a separate EEPROM master and takes that master's responses.

If the image passes both checks, the image becomes the active configuration. If either check fails, the block builds its default image and computes that image's checksum before issuing any write. It then opens the device for writing and writes back only the words that differ from the stored copy. Then it closes the device for writing. After that the defaults are the active configuration. Any other logic can read the active configuration through a word-address port once `done` is high. The `valid` and `repaired` flags report which path was taken.

The request channel is valid/ready. A raised request keeps its operation, address and data unchanged until the master accepts it, so the master may apply back-pressure for any number of cycles. Only one request is outstanding at a time. The response channel has no back-pressure: the block is always waiting when a response arrives, and it takes `rsp_valid` as a one-cycle pulse.

Top module: `cfg_image_keeper`

## Requirements
- R1: After reset the block reads word addresses 0 to 31 in ascending order. It issues exactly one read request per address and waits for that read's response before raising the next request.
- R2: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_op`, `req_addr` and `req_data` hold their values into the next cycle.
- R3: An image whose word 0 equals the signature constant and whose word 31 equals the 16-bit wraparound sum of words 0 to 30 is accepted. In that case `done` and `valid` rise, `repaired` stays low, and no request beyond the 32 reads is issued.
- R4: A word 0 that differs from the signature makes the image invalid even when the checksum word is consistent.
- R5: A correct signature with a checksum word that does not match the sum makes the image invalid.
- R6: For an invalid image the block issues one write-enable request, then one write per address whose default word differs from the stored word, in ascending address order and carrying the default word, then one write-disable request. Addresses whose words already match are not written.
- R7: The default word 31 is the 16-bit wraparound sum of default words 0 to 30. It is computed before the write-enable request and is written only if it differs from the stored word 31.
- R8: After a repair, `done` and `repaired` are high, `valid` is low, and the configuration port returns the default image. After an accepted image, the configuration port returns the stored image.
- R9: `done`, `valid` and `repaired` are low during reset and stay low until the sequence ends. They then hold their values, and no further request is issued until the next reset.
- R10: The operation codes on `req_op` are 0 = read, 1 = write, 2 = write-enable and 3 = write-disable.
- R11: The default image has the signature constant at word 0 and `DFLT_BASE + i*DFLT_STEP` (16-bit wraparound) at each word i from 1 to 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the sequence starts when it is released |
| req_valid | output | 1 | Request to the EEPROM master is pending |
| req_ready | input | 1 | EEPROM master accepts the request this cycle |
| req_op | output | 2 | Operation: 0 read, 1 write, 2 write-enable, 3 write-disable |
| req_addr | output | 5 | Word address for a read or write |
| req_data | output | 16 | Word to write |
| rsp_valid | input | 1 | One-cycle pulse marking completion of the outstanding request |
| rsp_data | input | 16 | Word returned by a read |
| cfg_addr | input | 5 | Configuration read address |
| cfg_data | output | 16 | Active configuration word at `cfg_addr` |
| done | output | 1 | Load, and repair if needed, has finished |
| valid | output | 1 | The stored image passed both checks |
| repaired | output | 1 | The defaults were written back |

## Verification
The hardest case to reach from the ports is a repair that touches exactly one address. The stored image has to equal the default image except at that address, and the bench must then confirm that all 31 other addresses stay untouched. The bench therefore sweeps a single flipped word across every address. A flip at address 0 breaks the signature. A flip at address 31 breaks only the checksum word and drives the write of the computed sum. A flip anywhere else breaks only the sum. Separate images cover a signature mismatch with a self-consistent checksum, a checksum off by one with a good signature, and blank devices. The EEPROM model stalls `req_ready` and delays responses at pseudo-random intervals, so back-pressure holds and response waits occur in every phase.

// File: rtl/cik_pkg.sv
package cik_pkg;

  // Operation codes sent to the EEPROM master (R10)
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WEN   = 2'd2,
    OP_WDIS  = 2'd3
  } nv_op_e;

  typedef enum logic [3:0] {
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_JUDGE,
    ST_SUM,
    ST_WEN_REQ,
    ST_WEN_WAIT,
    ST_CMP,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_WDS_REQ,
    ST_WDS_WAIT,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/cik_defaults.sv
module cik_defaults #(
  parameter int              WORDS     = 32,
  parameter int              DW        = 16,
  parameter int              SIG_IDX   = 0,
  parameter logic [DW-1:0]   SIG_VALUE = 16'hC0F1,
  parameter logic [DW-1:0]   BASE      = 16'h1234,
  parameter logic [DW-1:0]   STEP      = 16'h0F0F,
  localparam int             AW        = $clog2(WORDS)
) (
  input  logic [AW-1:0] idx,
  output logic [DW-1:0] word
);

  logic [DW-1:0] tbl [WORDS];

  // Default words are generated arithmetically; the checksum slot is
  // supplied by the sequencer, so its table entry is zero.
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    if (g == SIG_IDX) begin : g_sig
      assign tbl[g] = SIG_VALUE;
    end else if (g == WORDS - 1) begin : g_ck
      assign tbl[g] = '0;
    end else begin : g_lin
      assign tbl[g] = BASE + DW'(g) * STEP;
    end
  end

  assign word = tbl[idx];

endmodule

// File: rtl/cik_accum.sv
module cik_accum #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] sum
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum <= '0;
    else if (clr) sum <= '0;
    else if (add) sum <= sum + opnd;
  end

endmodule

// File: rtl/cik_store.sv
module cik_store #(
  parameter int  WORDS = 32,
  parameter int  DW    = 16,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] cfg_addr,
  output logic [DW-1:0] cfg_data
);

  logic [DW-1:0] word_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) word_q[i] <= '0;
    end else if (we) begin
      word_q[waddr] <= wdata;
    end
  end

  assign rdata    = word_q[raddr];
  assign cfg_data = word_q[cfg_addr];

endmodule

// File: rtl/cik_seq.sv
module cik_seq
  import cik_pkg::*;
#(
  parameter int            WORDS     = 32,
  parameter int            DW        = 16,
  parameter int            SIG_IDX   = 0,
  parameter logic [DW-1:0] SIG_VALUE = 16'hC0F1,
  localparam int           AW        = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          req_valid,
  input  logic          req_ready,
  output nv_op_e        req_op,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          rf_we,
  output logic [AW-1:0] rf_addr,
  output logic [DW-1:0] rf_wdata,
  input  logic [DW-1:0] rf_rdata,
  output logic          acc_clr,
  output logic          acc_add,
  output logic [DW-1:0] acc_in,
  input  logic [DW-1:0] acc_sum,
  input  logic [DW-1:0] dflt_word,
  output logic          done,
  output logic          valid,
  output logic          repaired
);

  localparam logic [AW-1:0] LAST_A = AW'(WORDS - 1);
  localparam logic [AW-1:0] SUML_A = AW'(WORDS - 2);
  localparam logic [AW-1:0] SIG_A  = AW'(SIG_IDX);

  seq_state_e    st;
  logic [AW-1:0] idx;
  logic          sig_ok, ck_ok, wen_seen;
  logic          last, sum_last, differ;
  logic [DW-1:0] dw_cur;

  assign last     = (idx == LAST_A);
  assign sum_last = (idx == SUML_A);
  assign dw_cur   = last ? acc_sum : dflt_word;
  assign differ   = (dw_cur != rf_rdata);
  assign rf_addr  = idx;

  always_comb begin
    req_valid = 1'b0;
    req_op    = OP_READ;
    req_addr  = idx;
    req_data  = '0;
    unique case (st)
      ST_RD_REQ:  req_valid = 1'b1;
      ST_WEN_REQ: begin req_valid = 1'b1; req_op = OP_WEN;  req_addr = '0; end
      ST_WR_REQ:  begin req_valid = 1'b1; req_op = OP_WRITE; req_data = dw_cur; end
      ST_WDS_REQ: begin req_valid = 1'b1; req_op = OP_WDIS; req_addr = '0; end
      default: ;
    endcase
  end

  always_comb begin
    acc_clr  = (st == ST_JUDGE);
    acc_add  = 1'b0;
    acc_in   = dflt_word;
    rf_we    = 1'b0;
    rf_wdata = dw_cur;
    unique case (st)
      ST_RD_WAIT: begin
        acc_add  = rsp_valid && !last;
        acc_in   = rsp_data;
        rf_we    = rsp_valid;
        rf_wdata = rsp_data;
      end
      ST_SUM:     acc_add = 1'b1;
      ST_CMP:     rf_we = !differ;
      ST_WR_WAIT: rf_we = rsp_valid;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_RD_REQ;
      idx      <= '0;
      sig_ok   <= 1'b0;
      ck_ok    <= 1'b0;
      wen_seen <= 1'b0;
      done     <= 1'b0;
      valid    <= 1'b0;
      repaired <= 1'b0;
    end else begin
      unique case (st)
        ST_RD_REQ: if (req_ready) st <= ST_RD_WAIT;
        ST_RD_WAIT: if (rsp_valid) begin
          if (idx == SIG_A) sig_ok <= (rsp_data == SIG_VALUE);
          if (last) begin
            ck_ok <= (rsp_data == acc_sum);
            st    <= ST_JUDGE;
          end else begin
            idx <= idx + AW'(1);
            st  <= ST_RD_REQ;
          end
        end
        ST_JUDGE: begin
          if (sig_ok && ck_ok) begin
            valid <= 1'b1;
            done  <= 1'b1;
            st    <= ST_DONE;
          end else begin
            idx <= '0;
            st  <= ST_SUM;
          end
        end
        ST_SUM: begin
          if (sum_last) begin
            idx <= '0;
            st  <= ST_WEN_REQ;
          end else begin
            idx <= idx + AW'(1);
          end
        end
        ST_WEN_REQ: if (req_ready) st <= ST_WEN_WAIT;
        ST_WEN_WAIT: if (rsp_valid) begin
          wen_seen <= 1'b1;
          st       <= ST_CMP;
        end
        ST_CMP: begin
          if (differ)    st <= ST_WR_REQ;
          else if (last) st <= ST_WDS_REQ;
          else           idx <= idx + AW'(1);
        end
        ST_WR_REQ: if (req_ready) st <= ST_WR_WAIT;
        ST_WR_WAIT: if (rsp_valid) begin
          if (last) st <= ST_WDS_REQ;
          else begin
            idx <= idx + AW'(1);
            st  <= ST_CMP;
          end
        end
        ST_WDS_REQ: if (req_ready) st <= ST_WDS_WAIT;
        ST_WDS_WAIT: if (rsp_valid) begin
          wen_seen <= 1'b0;
          done     <= 1'b1;
          repaired <= 1'b1;
          st       <= ST_DONE;
        end
        default: st <= ST_DONE;
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_op) && $stable(req_addr) && $stable(req_data)));

  // R1
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_valid);

  // R6
  write_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_WRITE) |-> wen_seen);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(valid) && $stable(repaired)));

  // R9
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  // R3
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid || repaired) |-> (done && !(valid && repaired)));

endmodule

// File: rtl/cfg_image_keeper.sv
module cfg_image_keeper
  import cik_pkg::*;
#(
  parameter int            WORDS     = 32,
  parameter int            DW        = 16,
  parameter int            SIG_IDX   = 0,
  parameter logic [DW-1:0] SIG_VALUE = 16'hC0F1,
  parameter logic [DW-1:0] DFLT_BASE = 16'h1234,
  parameter logic [DW-1:0] DFLT_STEP = 16'h0F0F,
  localparam int           AW        = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [1:0]    req_op,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic [AW-1:0] cfg_addr,
  output logic [DW-1:0] cfg_data,
  output logic          done,
  output logic          valid,
  output logic          repaired
);

  nv_op_e        op_e;
  logic          rf_we;
  logic [AW-1:0] rf_addr;
  logic [DW-1:0] rf_wdata, rf_rdata;
  logic          acc_clr, acc_add;
  logic [DW-1:0] acc_in, acc_sum, dflt_word;

  assign req_op = op_e;

  cik_seq #(
    .WORDS(WORDS), .DW(DW), .SIG_IDX(SIG_IDX), .SIG_VALUE(SIG_VALUE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(op_e),
    .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .acc_clr(acc_clr), .acc_add(acc_add), .acc_in(acc_in), .acc_sum(acc_sum),
    .dflt_word(dflt_word),
    .done(done), .valid(valid), .repaired(repaired)
  );

  cik_store #(.WORDS(WORDS), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .waddr(rf_addr), .wdata(rf_wdata),
    .raddr(rf_addr), .rdata(rf_rdata),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  cik_accum #(.DW(DW)) u_accum (
    .clk(clk), .rst_n(rst_n),
    .clr(acc_clr), .add(acc_add), .opnd(acc_in), .sum(acc_sum)
  );

  cik_defaults #(
    .WORDS(WORDS), .DW(DW), .SIG_IDX(SIG_IDX), .SIG_VALUE(SIG_VALUE),
    .BASE(DFLT_BASE), .STEP(DFLT_STEP)
  ) u_dflt (
    .idx(rf_addr), .word(dflt_word)
  );

endmodule

// File: tb/sim_cfg_image_keeper.sv
`timescale 1ns/1ps
module sim_cfg_image_keeper;
  import cik_pkg::*;

  localparam int          WORDS = 32;
  localparam logic [15:0] SIG   = 16'hC0F1;
  localparam logic [15:0] BASE  = 16'h1234;
  localparam logic [15:0] STEP  = 16'h0F0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid, req_ready, rsp_valid;
  logic [1:0]  req_op;
  logic [4:0]  req_addr, cfg_addr;
  logic [15:0] req_data, rsp_data, cfg_data;
  logic        done, valid, repaired;

  always #10 clk = ~clk;

  cfg_image_keeper #(
    .WORDS(WORDS), .DW(16), .SIG_VALUE(SIG), .DFLT_BASE(BASE), .DFLT_STEP(STEP)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .done(done), .valid(valid), .repaired(repaired)
  );

  logic [15:0] mem  [WORDS];
  logic [15:0] img  [WORDS];
  logic [15:0] dflt [WORDS];

  logic [1:0]  log_op   [128];
  logic [4:0]  log_addr [128];
  logic [15:0] log_data [128];
  int          log_n;

  // EEPROM master model with pseudo-random stalls and latency
  logic [15:0] lf;
  logic        busy, wen;
  logic [1:0]  cnt;
  logic [15:0] pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; wen <= 1'b0; cnt <= 2'd0; pend <= 16'd0;
      req_ready <= 1'b0; rsp_valid <= 1'b0; rsp_data <= 16'd0;
      log_n <= 0;
      lf <= 16'hACE1;
    end else begin
      lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rsp_valid <= 1'b0;
      if (busy) begin
        req_ready <= 1'b0;
        if (cnt == 2'd0) begin
          rsp_valid <= 1'b1;
          rsp_data  <= pend;
          busy      <= 1'b0;
        end else begin
          cnt <= cnt - 2'd1;
        end
      end else if (req_valid && req_ready) begin
        if (log_n < 128) begin
          log_op[log_n]   <= req_op;
          log_addr[log_n] <= req_addr;
          log_data[log_n] <= req_data;
          log_n <= log_n + 1;
        end
        case (req_op)
          2'd0: pend <= mem[req_addr];
          2'd1: if (wen) mem[req_addr] <= req_data;
          2'd2: wen <= 1'b1;
          default: wen <= 1'b0;
        endcase
        busy <= 1'b1;
        cnt  <= lf[1:0];
        req_ready <= 1'b0;
      end else begin
        req_ready <= lf[2] | lf[5];
      end
    end
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Back-pressure monitor (R2)
  logic       hold_pend = 1'b0;
  logic [4:0] hold_addr;
  logic [1:0] hold_op;
  always @(negedge clk) begin
    if (rst_n && hold_pend)
      chk(req_valid && req_addr == hold_addr && req_op == hold_op, "R2 request held",
          32'({req_valid, req_op, req_addr}), 32'({1'b1, hold_op, hold_addr}));
    hold_pend = rst_n && req_valid && !req_ready;
    hold_addr = req_addr;
    hold_op   = req_op;
  end

  function automatic logic [15:0] img_sum();
    logic [15:0] s = 16'd0;
    for (int i = 0; i < WORDS - 1; i++) s = s + img[i];
    return s;
  endfunction

  task automatic make_dflt();
    logic [15:0] s = 16'd0;
    dflt[0] = SIG;
    for (int i = 1; i < WORDS - 1; i++) dflt[i] = BASE + 16'(i) * STEP;
    for (int i = 0; i < WORDS - 1; i++) s = s + dflt[i];
    dflt[WORDS-1] = s;
  endtask

  task automatic run_case(input string name);
    bit          exp_valid;
    int          p;
    int          t;
    logic [15:0] expv;
    for (int i = 0; i < WORDS; i++) mem[i] = img[i];
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!done && !valid && !repaired, "R9 reset flags",
        32'({done, valid, repaired}), 0);
    rst_n = 1'b1;
    t = 0;
    while (!done && t < 6000) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, "R9 done reached", 32'(done), 1);
    exp_valid = (img[0] == SIG) && (img[WORDS-1] == img_sum());
    chk(valid == exp_valid, "R3 R4 R5 valid flag", 32'(valid), 32'(exp_valid));
    chk(repaired == !exp_valid, "R8 repaired flag", 32'(repaired), 32'(!exp_valid));
    for (int i = 0; i < WORDS; i++)
      chk(log_op[i] == 2'd0 && log_addr[i] == 5'(i), "R1 R10 read order",
          32'({log_op[i], log_addr[i]}), i);
    p = WORDS;
    if (!exp_valid) begin
      chk(log_op[p] == 2'd2, "R6 R10 enable first", 32'(log_op[p]), 2);
      p++;
      for (int i = 0; i < WORDS; i++) begin
        if (dflt[i] != img[i]) begin
          chk(log_op[p] == 2'd1 && log_addr[p] == 5'(i) && log_data[p] == dflt[i],
              (i == WORDS - 1) ? "R7 checksum write" : "R6 R11 differing write",
              32'({log_op[p], log_addr[p], log_data[p]}), 32'({2'd1, 5'(i), dflt[i]}));
          p++;
        end
      end
      chk(log_op[p] == 2'd3, "R6 R10 disable last", 32'(log_op[p]), 3);
      p++;
    end
    chk(log_n == p, "R6 R3 request count", log_n, p);
    repeat (20) @(negedge clk);
    chk(log_n == p && done, "R9 quiet after done", log_n, p);
    for (int a = 0; a < WORDS; a++) begin
      cfg_addr = 5'(a);
      #1;
      expv = exp_valid ? img[a] : dflt[a];
      chk(cfg_data == expv, "R8 R11 config port", 32'(cfg_data), 32'(expv));
      chk(mem[a] == expv, "R6 device image", 32'(mem[a]), 32'(expv));
    end
    $display("case %s done", name);
  endtask

  initial begin
    cfg_addr = 5'd0;
    make_dflt();
    // R3: arbitrary valid image whose sum wraps
    for (int i = 0; i < WORDS; i++) img[i] = 16'(i * 40503) ^ 16'h5A5A;
    img[0] = SIG;
    img[WORDS-1] = img_sum();
    run_case("valid random");
    // R3: device already holds the defaults
    for (int i = 0; i < WORDS; i++) img[i] = dflt[i];
    run_case("valid default");
    // R4 R5 R6 R7: one corrupted word at each address
    for (int k = 0; k < WORDS; k++) begin
      for (int i = 0; i < WORDS; i++) img[i] = dflt[i];
      img[k] = img[k] ^ 16'h8001;
      run_case("single flip");
    end
    // blank devices
    for (int i = 0; i < WORDS; i++) img[i] = 16'h0000;
    run_case("blank zero");
    for (int i = 0; i < WORDS; i++) img[i] = 16'hFFFF;
    run_case("blank ones");
    // R4: wrong signature, consistent checksum
    for (int i = 0; i < WORDS; i++) img[i] = 16'(i * 7919) + 16'h0101;
    img[0] = SIG ^ 16'h0001;
    img[WORDS-1] = img_sum();
    run_case("bad signature");
    // R5: good signature, checksum off by one
    for (int i = 0; i < WORDS; i++) img[i] = 16'(i * 31337) ^ 16'hF00D;
    img[0] = SIG;
    img[WORDS-1] = img_sum() + 16'd1;
    run_case("bad checksum");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule